// File: doc/BRIEF.md
# 8-bit ALU with Per-Operation Flag Masking

This block is the single-cycle arithmetic and logic unit of a small 8-bit RISC core. In one clock cycle it takes two register operands, an optional immediate operand and the current carry and zero flags. It produces a result byte, a write-enable for the register file, new values for six status flags and a mask that says which of those flags the operation changes. The block is purely combinational. The core that uses it registers the result and merges the masked flags into its status register on the next edge.

Each operation changes its own subset of the flags. The flags it leaves alone keep their old value in the core. Half-carry is taken at the boundary between bit 3 and bit 4. The three compare operations compute a subtraction and change the flags, but they never request a register write. Subtract-with-carry and compare-with-carry can only keep an existing zero flag set, so that a multi-byte compare or subtract works when the bytes are chained.

Top module: `alu8_core`

## Requirements
- R1: `op_i` codes are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 negate, 9 increment, 10 decrement, 11 compare, 12 compare-with-carry, 13 compare-immediate. Add and add-with-carry give (A + B [+ c_in]) mod 256, with C as the carry out of bit 7, H as the carry out of bit 3, and V set on signed overflow.
- R2: Subtract and subtract-with-carry give (A − B [− c_in]) mod 256, with C as the borrow out of bit 7, H as the borrow out of bit 3, and V set on signed overflow.
- R3: For subtract-with-carry and compare-with-carry, Z = (result == 0) AND z_in_i. A zero result never sets a Z that was clear.
- R4: AND, OR and XOR set V = 0 and have a mask of exactly {Z, N, V, S}. C and H are not in the mask.
- R5: Increment and decrement change only {Z, N, V, S}. V is set exactly when A is 0x7F (increment) or 0x80 (decrement).
- R6: One's complement returns 0xFF − A with C = 1 and V = 0, and has a mask of exactly {C, Z, N, V, S}.
- R7: Negate returns 0x00 − A with C = (result ≠ 0), V = (result == 0x80) and H as the borrow out of bit 3. All six flags are in its mask.
- R8: The compare operations drive wr_en_o low and set the flags exactly as subtract (11, 13) or subtract-with-carry (12) would. Compare-immediate always takes imm_i as its B operand.
- R9: S = N XOR V for every operation that changes S.
- R10: N equals result bit 7. Outside the chained operations of R3, Z = (result == 0).
- R11: When imm_sel_i is 1, imm_i replaces opb_i as the B operand of every operation.
- R12: Codes 14 and 15 drive wr_en_o low and a mask of zero. Codes 0–10 drive wr_en_o high.
- R13: The flag bit positions in `flags_o` and `fmask_o` are C=0, Z=1, N=2, V=3, S=4, H=5. A flag bit outside the mask reads 0. Every operation completes in the same cycle, so the outputs depend only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (see R1) |
| opa_i | input | 8 | First register operand (A) |
| opb_i | input | 8 | Second register operand (B) |
| imm_i | input | 8 | Immediate operand |
| imm_sel_i | input | 1 | Use imm_i as the B operand |
| c_in_i | input | 1 | Current carry flag |
| z_in_i | input | 1 | Current zero flag, used for chained ops |
| res_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result is to be written back |
| flags_o | output | 6 | New flag values, masked |
| fmask_o | output | 6 | Flags changed by this operation |

## Verification
The block holds no state, so a fault in decode, in the shared adder or in flag formation shows at the ports in the same cycle as the operation that exposes it. Faults stay hidden until the right operand corner is applied. Examples are a wrong nibble carry, which shows only when bits 3:0 overflow, a wrong overflow term, which shows only when the signs cross, or a dropped Z chain, which shows only with z_in_i low and a zero difference. The directed vectors target each of those corners for every operation class, and a sweep over all sixteen codes compares the outputs against an independent arithmetic model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
      OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_COM = 4'd7,
      OP_NEG = 4'd8,  OP_INC = 4'd9,  OP_DEC = 4'd10, OP_CP  = 4'd11,
      OP_CPC = 4'd12, OP_CPI = 4'd13
   } alu_op_e;

   // flag bit positions inside flags/mask vectors
   localparam int FLAG_W = 6;
   localparam int FB_C = 0;
   localparam int FB_Z = 1;
   localparam int FB_N = 2;
   localparam int FB_V = 3;
   localparam int FB_S = 4;
   localparam int FB_H = 5;

   typedef enum logic [2:0] {
      CL_NONE, CL_ARITH, CL_STEP, CL_LOGIC, CL_COM
   } alu_cls_e;

   typedef enum logic [1:0] {
      CIN_ZERO, CIN_ONE, CIN_FLAG
   } cin_sel_e;

   typedef struct packed {
      logic     sub;       // adder subtracts
      logic     a_zero;    // adder A forced to zero (negate)
      logic     b_from_a;  // adder B taken from operand A (negate)
      logic     b_zero;    // adder B forced to zero (inc/dec)
      cin_sel_e cin_sel;   // carry/borrow into bit 0
      alu_cls_e cls;       // flag formation class
      logic     chain_z;   // Z only kept, never newly set
      logic     wr;        // write-back request
   } alu_ctl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
   import alu8_pkg::*;
(
   input  logic [3:0] op_i,
   output alu_ctl_t   ctl_o
);

   always_comb begin
      ctl_o = '{sub: 1'b0, a_zero: 1'b0, b_from_a: 1'b0, b_zero: 1'b0,
                cin_sel: CIN_ZERO, cls: CL_NONE, chain_z: 1'b0, wr: 1'b0};
      case (alu_op_e'(op_i))
         OP_ADD: begin ctl_o.cls = CL_ARITH; ctl_o.wr = 1'b1; end
         OP_ADC: begin ctl_o.cls = CL_ARITH; ctl_o.wr = 1'b1; ctl_o.cin_sel = CIN_FLAG; end
         OP_SUB, OP_CP, OP_CPI: begin
            ctl_o.cls = CL_ARITH;
            ctl_o.sub = 1'b1;
            ctl_o.wr  = (alu_op_e'(op_i) == OP_SUB);
         end
         OP_SBC, OP_CPC: begin
            ctl_o.cls     = CL_ARITH;
            ctl_o.sub     = 1'b1;
            ctl_o.cin_sel = CIN_FLAG;
            ctl_o.chain_z = 1'b1;
            ctl_o.wr      = (alu_op_e'(op_i) == OP_SBC);
         end
         OP_AND, OP_OR, OP_XOR: begin ctl_o.cls = CL_LOGIC; ctl_o.wr = 1'b1; end
         OP_COM: begin ctl_o.cls = CL_COM; ctl_o.wr = 1'b1; end
         OP_NEG: begin
            ctl_o.cls      = CL_ARITH;
            ctl_o.sub      = 1'b1;
            ctl_o.a_zero   = 1'b1;
            ctl_o.b_from_a = 1'b1;
            ctl_o.wr       = 1'b1;
         end
         OP_INC, OP_DEC: begin
            ctl_o.cls     = CL_STEP;
            ctl_o.b_zero  = 1'b1;
            ctl_o.cin_sel = CIN_ONE;
            ctl_o.sub     = (alu_op_e'(op_i) == OP_DEC);
            ctl_o.wr      = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W     = 8,
   parameter int NIB   = 4,
   parameter bit SPLIT = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   input  logic         cin_i,   // carry for add, borrow for subtract
   output logic [W-1:0] sum_o,
   output logic         cy_o,    // carry out, or borrow out when subtracting
   output logic         hc_o,    // carry/borrow out of the low nibble
   output logic         ov_o
);

   localparam int HW = W - NIB;

   if (W < NIB + 1) begin : g_bad_width
      $error("alu8_addsub: W must exceed NIB");
   end

   logic [W-1:0] bb;
   logic         ci, cy, hc;

   assign bb = sub_i ? ~b_i : b_i;
   assign ci = sub_i ? ~cin_i : cin_i;

   if (SPLIT) begin : g_split
      logic [NIB:0] lo;
      logic [HW:0]  hi;
      assign lo    = {1'b0, a_i[NIB-1:0]} + {1'b0, bb[NIB-1:0]} + {{NIB{1'b0}}, ci};
      assign hi    = {1'b0, a_i[W-1:NIB]} + {1'b0, bb[W-1:NIB]} + {{HW{1'b0}}, lo[NIB]};
      assign sum_o = {hi[HW-1:0], lo[NIB-1:0]};
      assign cy    = hi[HW];
      assign hc    = lo[NIB];
   end else begin : g_flat
      logic [W:0] full;
      assign full  = {1'b0, a_i} + {1'b0, bb} + {{W{1'b0}}, ci};
      assign sum_o = full[W-1:0];
      assign cy    = full[W];
      assign hc    = a_i[NIB] ^ bb[NIB] ^ full[NIB];
   end

   assign cy_o = cy ^ sub_i;
   assign hc_o = hc ^ sub_i;
   assign ov_o = (a_i[W-1] == bb[W-1]) && (sum_o[W-1] != a_i[W-1]);

   always_comb begin
      if (!sub_i) begin
         a_r1_add_exact: assert ({cy_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}));
      end else begin
         a_r2_borrow_exact: assert (cy_o == ({1'b0, a_i} < ({1'b0, b_i} + {{W{1'b0}}, cin_i})));
      end
   end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [3:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] y_o
);

   always_comb begin
      case (alu_op_e'(op_i))
         OP_AND:  y_o = a_i & b_i;
         OP_OR:   y_o = a_i | b_i;
         OP_XOR:  y_o = a_i ^ b_i;
         OP_COM:  y_o = ~a_i;
         default: y_o = '0;
      endcase
   end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_cls_e          cls_i,
   input  logic              chain_z_i,
   input  logic              wr_i,
   input  logic [W-1:0]      sum_i,
   input  logic              cy_i,
   input  logic              hc_i,
   input  logic              ov_i,
   input  logic [W-1:0]      lres_i,
   input  logic              z_in_i,
   output logic [W-1:0]      res_o,
   output logic              wr_en_o,
   output logic [FLAG_W-1:0] flags_o,
   output logic [FLAG_W-1:0] mask_o
);

   localparam logic [FLAG_W-1:0] M_ALL = '1;
   localparam logic [FLAG_W-1:0] M_ZNVS =
      FLAG_W'((1 << FB_Z) | (1 << FB_N) | (1 << FB_V) | (1 << FB_S));
   localparam logic [FLAG_W-1:0] M_COMP = M_ZNVS | FLAG_W'(1 << FB_C);

   logic [FLAG_W-1:0] raw;
   logic              n, v, z;

   always_comb begin
      res_o = (cls_i == CL_LOGIC || cls_i == CL_COM) ? lres_i : sum_i;
      n     = res_o[W-1];
      z     = (res_o == '0) && (!chain_z_i || z_in_i);
      v     = (cls_i == CL_ARITH || cls_i == CL_STEP) ? ov_i : 1'b0;
      raw   = '0;
      raw[FB_N] = n;
      raw[FB_Z] = z;
      raw[FB_V] = v;
      raw[FB_S] = n ^ v;
      raw[FB_C] = (cls_i == CL_COM) ? 1'b1 : cy_i;
      raw[FB_H] = hc_i;
      case (cls_i)
         CL_ARITH:          mask_o = M_ALL;
         CL_STEP, CL_LOGIC: mask_o = M_ZNVS;
         CL_COM:            mask_o = M_COMP;
         default:           mask_o = '0;
      endcase
      flags_o = raw & mask_o;
      wr_en_o = wr_i;
   end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W     = 8,
   parameter bit SPLIT = 1'b1
) (
   input  logic [3:0]   op_i,
   input  logic [W-1:0] opa_i,
   input  logic [W-1:0] opb_i,
   input  logic [W-1:0] imm_i,
   input  logic         imm_sel_i,
   input  logic         c_in_i,
   input  logic         z_in_i,
   output logic [W-1:0] res_o,
   output logic         wr_en_o,
   output logic [5:0]   flags_o,
   output logic [5:0]   fmask_o
);

   if (FLAG_W != 6) begin : g_bad_flags
      $error("alu8_core: flag vector width mismatch");
   end

   alu_ctl_t     ctl;
   logic [W-1:0] b_pick, add_a, add_b, sum, lres;
   logic         add_cin, cy, hc, ov;

   alu8_decode u_dec (.op_i(op_i), .ctl_o(ctl));

   assign b_pick  = (imm_sel_i || alu_op_e'(op_i) == OP_CPI) ? imm_i : opb_i;
   assign add_a   = ctl.a_zero ? '0 : opa_i;
   assign add_b   = ctl.b_zero ? '0 : (ctl.b_from_a ? opa_i : b_pick);
   assign add_cin = (ctl.cin_sel == CIN_ONE) | ((ctl.cin_sel == CIN_FLAG) & c_in_i);

   alu8_addsub #(.W(W), .SPLIT(SPLIT)) u_add (
      .a_i(add_a), .b_i(add_b), .sub_i(ctl.sub), .cin_i(add_cin),
      .sum_o(sum), .cy_o(cy), .hc_o(hc), .ov_o(ov)
   );

   alu8_logic #(.W(W)) u_log (
      .op_i(op_i), .a_i(opa_i), .b_i(b_pick), .y_o(lres)
   );

   alu8_flags #(.W(W)) u_flg (
      .cls_i(ctl.cls), .chain_z_i(ctl.chain_z), .wr_i(ctl.wr),
      .sum_i(sum), .cy_i(cy), .hc_i(hc), .ov_i(ov), .lres_i(lres),
      .z_in_i(z_in_i), .res_o(res_o), .wr_en_o(wr_en_o),
      .flags_o(flags_o), .mask_o(fmask_o)
   );

   always_comb begin
      if (op_i >= 4'd14) begin
         a_r12_unused_quiet: assert (!wr_en_o && fmask_o == '0);
      end
      if (alu_op_e'(op_i) inside {OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC}) begin
         a_r4_keep_c_h: assert (!fmask_o[FB_C] && !fmask_o[FB_H]);
      end
      if (alu_op_e'(op_i) == OP_COM) begin
         a_r6_com_carry: assert (flags_o[FB_C] && res_o == ~opa_i);
      end
      if (alu_op_e'(op_i) inside {OP_CP, OP_CPC, OP_CPI}) begin
         a_r8_cmp_no_write: assert (!wr_en_o);
      end
      if (fmask_o[FB_Z] && alu_op_e'(op_i) != OP_SBC && alu_op_e'(op_i) != OP_CPC) begin
         a_r10_z_tracks_res: assert (flags_o[FB_Z] == (res_o == '0));
      end
   end

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;

   logic       clk = 1'b0;
   logic [3:0] op;
   logic [7:0] a, b, imm;
   logic       sel, cin, zin;
   logic [7:0] res;
   logic       we;
   logic [5:0] flg, msk;
   int         tests = 0;
   int         fails = 0;

   always #2 clk = ~clk;   // 250 MHz

   alu8_core u0 (
      .op_i(op), .opa_i(a), .opb_i(b), .imm_i(imm), .imm_sel_i(sel),
      .c_in_i(cin), .z_in_i(zin), .res_o(res), .wr_en_o(we),
      .flags_o(flg), .fmask_o(msk)
   );

   // independent model of the requirements
   task automatic model(input logic [3:0] o, input logic [7:0] x, y, im,
                        input logic s, c, z,
                        output logic [7:0] r, output logic w,
                        output logic [5:0] f, output logic [5:0] m);
      int bo, k, t;
      logic cf, hf, vf, nf, zf, chain;
      bo = (s || o == 4'd13) ? int'(im) : int'(y);
      cf = 0; hf = 0; vf = 0; chain = 0; r = 0; w = 1; m = 6'h3F;
      k  = (o == 4'd1 || o == 4'd3 || o == 4'd12) ? int'(c) : 0;
      case (o)
         4'd0, 4'd1: begin
            t  = int'(x) + bo + k;
            r  = 8'(t);
            cf = t > 255;
            hf = ((int'(x) % 16) + (bo % 16) + k) > 15;
            vf = (x[7] == bo[7]) && (r[7] != x[7]);
         end
         4'd2, 4'd3, 4'd11, 4'd12, 4'd13: begin
            r  = 8'(int'(x) - bo - k);
            cf = int'(x) < bo + k;
            hf = (int'(x) % 16) < (bo % 16) + k;
            vf = (x[7] != bo[7]) && (r[7] != x[7]);
            chain = (o == 4'd3 || o == 4'd12);
            w  = !(o >= 4'd11);
         end
         4'd4: begin r = x & 8'(bo); m = 6'h1E; end
         4'd5: begin r = x | 8'(bo); m = 6'h1E; end
         4'd6: begin r = x ^ 8'(bo); m = 6'h1E; end
         4'd7: begin r = 8'hFF - x; cf = 1; m = 6'h1F; end
         4'd8: begin
            r  = 8'(0 - int'(x));
            cf = r != 0;
            hf = (int'(x) % 16) != 0;
            vf = r == 8'h80;
         end
         4'd9:  begin r = x + 8'd1; vf = x == 8'h7F; m = 6'h1E; end
         4'd10: begin r = x - 8'd1; vf = x == 8'h80; m = 6'h1E; end
         default: begin w = 0; m = 6'h00; end
      endcase
      nf = r[7];
      zf = (r == 0) && (!chain || z);
      f  = {hf, nf ^ vf, vf, nf, zf, cf} & m;
   endtask

   task automatic apply(input logic [3:0] o, input logic [7:0] x, y, im,
                        input logic s, c, z, input string tag);
      logic [7:0] er; logic ew; logic [5:0] ef, em;
      @(posedge clk);
      op = o; a = x; b = y; imm = im; sel = s; cin = c; zin = z;
      @(negedge clk);
      model(o, x, y, im, s, c, z, er, ew, ef, em);
      tests++;
      if (we !== ew || msk !== em || flg !== ef || (ew && res !== er)) begin
         fails++;
         $display("FAIL %s op=%0d a=%h b=%h: got res=%h we=%b f=%b m=%b exp res=%h we=%b f=%b m=%b",
                  tag, o, x, y, res, we, flg, msk, er, ew, ef, em);
      end
   endtask

   task automatic t_idle();       // R12 R13
      apply(4'd15, 8'h12, 8'h34, 8'h00, 0, 1, 1, "R12 unused code");
      apply(4'd14, 8'h00, 8'h00, 8'h00, 0, 0, 0, "R12 unused code");
   endtask

   task automatic t_add();        // R1 R9 R10
      apply(4'd0, 8'h0F, 8'h01, 8'h00, 0, 0, 0, "R1 half carry");
      apply(4'd0, 8'h7F, 8'h01, 8'h00, 0, 0, 0, "R1 overflow R9");
      apply(4'd0, 8'hFF, 8'h01, 8'h00, 0, 0, 0, "R1 carry zero R10");
      apply(4'd1, 8'h80, 8'h7F, 8'h00, 0, 1, 0, "R1 adc carry in");
   endtask

   task automatic t_sub();        // R2 R3
      apply(4'd2, 8'h10, 8'h01, 8'h00, 0, 0, 0, "R2 half borrow");
      apply(4'd2, 8'h80, 8'h01, 8'h00, 0, 0, 0, "R2 overflow");
      apply(4'd2, 8'h00, 8'h01, 8'h00, 0, 0, 0, "R2 borrow");
      apply(4'd3, 8'h05, 8'h05, 8'h00, 0, 0, 0, "R3 chain z clear");
      apply(4'd3, 8'h05, 8'h05, 8'h00, 0, 0, 1, "R3 chain z kept");
      apply(4'd3, 8'h05, 8'h04, 8'h00, 0, 1, 1, "R3 sbc borrow in");
   endtask

   task automatic t_logic();      // R4
      apply(4'd4, 8'hF0, 8'h3C, 8'h00, 0, 1, 0, "R4 and");
      apply(4'd5, 8'h80, 8'h01, 8'h00, 0, 1, 0, "R4 or");
      apply(4'd6, 8'hAA, 8'hAA, 8'h00, 0, 1, 0, "R4 xor zero");
   endtask

   task automatic t_step();       // R5
      apply(4'd9,  8'h7F, 8'h00, 8'h00, 0, 1, 0, "R5 inc overflow");
      apply(4'd9,  8'hFF, 8'h00, 8'h00, 0, 0, 0, "R5 inc wrap");
      apply(4'd10, 8'h80, 8'h00, 8'h00, 0, 1, 0, "R5 dec overflow");
      apply(4'd10, 8'h00, 8'h00, 8'h00, 0, 0, 0, "R5 dec wrap");
   endtask

   task automatic t_com_neg();    // R6 R7
      apply(4'd7, 8'h00, 8'h00, 8'h00, 0, 0, 0, "R6 com zero");
      apply(4'd7, 8'h5A, 8'h00, 8'h00, 0, 0, 0, "R6 com");
      apply(4'd8, 8'h00, 8'h00, 8'h00, 0, 1, 0, "R7 neg zero");
      apply(4'd8, 8'h80, 8'h00, 8'h00, 0, 0, 0, "R7 neg 0x80");
      apply(4'd8, 8'h01, 8'h00, 8'h00, 0, 0, 0, "R7 neg one");
   endtask

   task automatic t_cmp();        // R8
      apply(4'd11, 8'h33, 8'h33, 8'h00, 0, 0, 0, "R8 cp equal");
      apply(4'd12, 8'h33, 8'h33, 8'h00, 0, 1, 1, "R8 cpc");
      apply(4'd13, 8'h20, 8'h20, 8'h21, 0, 0, 0, "R8 cpi uses imm");
   endtask

   task automatic t_imm();        // R11
      apply(4'd0, 8'h10, 8'hFF, 8'h05, 1, 0, 0, "R11 add imm");
      apply(4'd4, 8'hFF, 8'h00, 8'h0F, 1, 0, 0, "R11 and imm");
   endtask

   task automatic t_sweep();      // R13 all codes
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 4; j++) begin
            apply(4'(i), 8'(i * 37 + j * 61), 8'(i * 91 + j * 13), 8'(j * 77),
                  j[0], j[1], j[0] ^ j[1], "R13 sweep");
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      op = 4'd15; a = 0; b = 0; imm = 0; sel = 0; cin = 0; zin = 0;
      repeat (2) @(posedge clk);
      t_idle();
      t_add();
      t_sub();
      t_logic();
      t_step();
      t_com_neg();
      t_cmp();
      t_imm();
      t_sweep();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule